// File: doc/BRIEF.md
# Two-Register Ring Self-Test Sequencer

This block runs a built-in self-test on two combinational networks wired in a ring between two multi-mode test registers. Register A drives network one, whose outputs land in register B; register B drives network two, whose outputs land back in register A. Each register can shift serially, free-run as a pseudo-random pattern generator, fold its parallel input into a running signature, clear itself, or hold. A sequencer drives both registers' mode controls and serial inputs, counts cycles, and collects the signatures as they are shifted out.

The test has two phases, and the registers swap roles between them. In phase one, register A is seeded and runs as the generator while register B builds a signature of network one. Register B's signature is then shifted out and compared. In that same step register B is re-seeded for network two and register A is cleared. Phase two repeats the run with the roles reversed, and register A's signature is shifted out last. Run lengths, seeds and expected signatures are parameters. A fault-injection input forces one output wire of network one to a stuck value, so that a failing signature can be demonstrated.

Top module: `ring_selftest`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to idle with done, pass1 and pass2 low.
- R2: A start pulse sampled in idle or finished state begins a run. done goes high on the rising edge that is 3*W + RUN1_LEN + RUN2_LEN edges after the edge that sampled start.
- R3: Both registers step through the same linear recurrence, with next = {q[W-2:0], ^(q & TAPS)} (default TAPS 4'b1100, W=4). The generator uses this value alone. The compactor XORs it with its parallel input.
- R4: In phase one, SEED1 is shifted into register A most significant bit first over W clocks while register B is cleared. Register A then generates and register B compacts network one's output for RUN1_LEN clocks.
- R5: pass1 is high exactly when register B's signature, shifted out MSB first over W clocks, equals EXP1.
- R6: During phase one's unload, SEED2 is shifted into register B MSB first and register A is cleared. Register B then generates and register A compacts network two's output for RUN2_LEN clocks. pass2 is high exactly when register A's shifted-out signature equals EXP2.
- R7: Network one computes y[i] = x[i] ^ (x[(i+1)%W] & x[(i+2)%W]). Network two computes y[i] = ~(x[i] ^ x[(i+W-1)%W]).
- R8: While inject_fault is high, output bit FAULT_BIT of network one is forced to FAULT_VAL. This changes pass1 as the arithmetic predicts and leaves pass2 unaffected.
- R9: done, pass1 and pass2 hold their values from the finished state until the next start.
- R10: A start pulse during a run is ignored and does not change the completion time.
- R11: A start from the finished state clears done, pass1 and pass2 on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run the self-test |
| inject_fault | input | 1 | Forces a stuck value on one wire of network one |
| done | output | 1 | Self-test finished |
| pass1 | output | 1 | Phase-one signature matched EXP1 |
| pass2 | output | 1 | Phase-two signature matched EXP2 |

## Verification
The bench computes both signatures arithmetically at elaboration, for two parameter sets. One set has long runs and matching expectations. The other has one- and two-cycle runs and a deliberately wrong phase-one expectation. Runs with and without the injected fault separate a correct compare from a stuck compare, and show that the fault reaches only the phase-one result. Runs that include a stray start mid-test, followed by idle stretches, check the completion latency, the ignored start, the clearing on restart and the held results.

// File: rtl/ring_selftest_pkg.sv
// Shared types for the ring self-test: register operating modes and
// sequencer states. Assumes a 3-bit encoding is enough for both.
package ring_selftest_pkg;
    typedef enum logic [2:0] {
        RM_HOLD,
        RM_SHIFT,
        RM_GEN,
        RM_COMPACT,
        RM_CLEAR
    } reg_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN1,
        ST_RUN1,
        ST_UNLOAD1,
        ST_RUN2,
        ST_UNLOAD2,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/tst_reg.sv
// Multi-mode test register: serial shift, free-running pattern generator,
// parallel-input signature compactor, clear and hold.
// Assumes W >= 2; serial data enters at bit 0 and leaves from bit W-1.
module tst_reg
    import ring_selftest_pkg::*;
#(
    parameter int          W    = 4,
    parameter logic [W-1:0] TAPS = 4'b1100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_mode_e    mode,
    input  logic         scan_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q,
    output logic         scan_out
);
    logic [W-1:0] step_val;

    // Linear recurrence shared by generator and compactor.
    always_comb step_val = {q[W-2:0], ^(q & TAPS)};

    // Register update chosen by the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (mode)
                RM_SHIFT:   q <= {q[W-2:0], scan_in};
                RM_GEN:     q <= step_val;
                RM_COMPACT: q <= step_val ^ par_in;
                RM_CLEAR:   q <= '0;
                default:    q <= q;
            endcase
        end
    end

    assign scan_out = q[W-1];

    assert_shift_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_SHIFT) |=> (q == {$past(q[W-2:0]), $past(scan_in)}));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_CLEAR) |=> (q == '0));
endmodule

// File: rtl/example_net.sv
// Small example combinational network. KIND 0 is an XOR/AND mix that
// carries an optional stuck-at override on one output; KIND 1 is an
// XNOR of neighbouring bits. Assumes W >= 3 and FAULT_BIT < W.
module example_net #(
    parameter int   W         = 4,
    parameter int   KIND      = 0,
    parameter int   FAULT_BIT = 0,
    parameter logic FAULT_VAL = 1'b1
) (
    input  logic [W-1:0] x,
    input  logic         fault_en,
    output logic [W-1:0] y
);
    logic [W-1:0] y_raw;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            localparam int NB1 = (i + 1) % W;
            localparam int NB2 = (i + 2) % W;
            localparam int PRV = (i + W - 1) % W;
            if (KIND == 0) begin : g_mix
                assign y_raw[i] = x[i] ^ (x[NB1] & x[NB2]);
            end else begin : g_xnor
                assign y_raw[i] = ~(x[i] ^ x[PRV]);
            end
        end
    endgenerate

    // Stuck-at override of one output wire while fault_en is high.
    always_comb begin
        y = y_raw;
        if (fault_en) y[FAULT_BIT] = FAULT_VAL;
    end
endmodule

// File: rtl/selftest_seq.sv
// Sequencer for the two-phase ring self-test. It drives both registers'
// modes and serial inputs, counts each step, captures shifted-out
// signatures and latches pass/done. Assumes W >= 2 and run lengths >= 1.
module selftest_seq
    import ring_selftest_pkg::*;
#(
    parameter int           W        = 4,
    parameter int           RUN1_LEN = 6,
    parameter int           RUN2_LEN = 5,
    parameter logic [W-1:0] SEED1    = 4'b1000,
    parameter logic [W-1:0] SEED2    = 4'b0110,
    parameter logic [W-1:0] EXP1     = 4'b0001,
    parameter logic [W-1:0] EXP2     = 4'b0000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      so_a,
    input  logic      so_b,
    output reg_mode_e mode_a,
    output reg_mode_e mode_b,
    output logic      si_a,
    output logic      si_b,
    output logic      done,
    output logic      pass1,
    output logic      pass2
);
    localparam int MAXLEN = (W > RUN1_LEN) ? ((W > RUN2_LEN) ? W : RUN2_LEN)
                                           : ((RUN1_LEN > RUN2_LEN) ? RUN1_LEN : RUN2_LEN);
    localparam int CW = $clog2(MAXLEN + 1);

    seq_state_e   state;
    logic [CW-1:0] cnt;
    logic          last;
    logic          idle_like;
    logic [W-1:0]  cap;
    logic [W-1:0]  seed_a_sh, seed_b_sh;
    logic [W-1:0]  sig_a_now, sig_b_now;

    // Final-cycle detect for the current step.
    always_comb begin
        case (state)
            ST_SCAN1, ST_UNLOAD1, ST_UNLOAD2: last = (cnt == CW'(W - 1));
            ST_RUN1: last = (cnt == CW'(RUN1_LEN - 1));
            ST_RUN2: last = (cnt == CW'(RUN2_LEN - 1));
            default: last = 1'b0;
        endcase
    end

    assign idle_like = (state == ST_IDLE) || (state == ST_DONE);

    // Step sequencing and per-step cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (idle_like) begin
            if (start) begin
                state <= ST_SCAN1;
                cnt   <= '0;
            end
        end else if (last) begin
            cnt <= '0;
            case (state)
                ST_SCAN1:   state <= ST_RUN1;
                ST_RUN1:    state <= ST_UNLOAD1;
                ST_UNLOAD1: state <= ST_RUN2;
                ST_RUN2:    state <= ST_UNLOAD2;
                default:    state <= ST_DONE;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Seed bits presented MSB first, one per shift cycle.
    always_comb begin
        seed_a_sh = SEED1 << cnt;
        seed_b_sh = SEED2 << cnt;
    end

    // Mode and serial-input decode per step.
    always_comb begin
        mode_a = RM_HOLD;
        mode_b = RM_HOLD;
        si_a   = 1'b0;
        si_b   = 1'b0;
        case (state)
            ST_SCAN1:   begin mode_a = RM_SHIFT; si_a = seed_a_sh[W-1]; mode_b = RM_CLEAR; end
            ST_RUN1:    begin mode_a = RM_GEN;   mode_b = RM_COMPACT; end
            ST_UNLOAD1: begin mode_b = RM_SHIFT; si_b = seed_b_sh[W-1]; mode_a = RM_CLEAR; end
            ST_RUN2:    begin mode_b = RM_GEN;   mode_a = RM_COMPACT; end
            ST_UNLOAD2: begin mode_a = RM_SHIFT; end
            default:    ;
        endcase
    end

    assign sig_b_now = {cap[W-2:0], so_b};
    assign sig_a_now = {cap[W-2:0], so_a};

    // Signature capture, comparison and result latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap   <= '0;
            done  <= 1'b0;
            pass1 <= 1'b0;
            pass2 <= 1'b0;
        end else begin
            if (idle_like && start) begin
                done  <= 1'b0;
                pass1 <= 1'b0;
                pass2 <= 1'b0;
            end
            if (state == ST_UNLOAD1) begin
                cap <= sig_b_now;
                if (last) pass1 <= (sig_b_now == EXP1);
            end
            if (state == ST_UNLOAD2) begin
                cap <= sig_a_now;
                if (last) begin
                    pass2 <= (sig_a_now == EXP2);
                    done  <= 1'b1;
                end
            end
        end
    end

    assert_results_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass1) && $stable(pass2)));

    assert_done_from_unload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == ST_UNLOAD2));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_like && start) |=> !(state == ST_SCAN1 && cnt == '0));

    assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && start) |=> (!done && !pass1 && !pass2 && state == ST_SCAN1));
endmodule

// File: rtl/ring_selftest.sv
// Top of the ring self-test: two test registers, two example networks in
// a ring, and the sequencer. Assumes the expected signatures match the
// chosen seeds, taps and run lengths.
module ring_selftest
    import ring_selftest_pkg::*;
#(
    parameter int           W         = 4,
    parameter logic [W-1:0] TAPS      = 4'b1100,
    parameter int           RUN1_LEN  = 6,
    parameter int           RUN2_LEN  = 5,
    parameter logic [W-1:0] SEED1     = 4'b1000,
    parameter logic [W-1:0] SEED2     = 4'b0110,
    parameter logic [W-1:0] EXP1      = 4'b0001,
    parameter logic [W-1:0] EXP2      = 4'b0000,
    parameter int           FAULT_BIT = 0,
    parameter logic         FAULT_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic inject_fault,
    output logic done,
    output logic pass1,
    output logic pass2
);
    reg_mode_e    mode_a, mode_b;
    logic         si_a, si_b, so_a, so_b;
    logic [W-1:0] q_a, q_b, net1_y, net2_y;

    tst_reg #(.W(W), .TAPS(TAPS)) reg_a_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_a), .scan_in(si_a),
        .par_in(net2_y), .q(q_a), .scan_out(so_a)
    );

    tst_reg #(.W(W), .TAPS(TAPS)) reg_b_i (
        .clk(clk), .rst_n(rst_n), .mode(mode_b), .scan_in(si_b),
        .par_in(net1_y), .q(q_b), .scan_out(so_b)
    );

    example_net #(.W(W), .KIND(0), .FAULT_BIT(FAULT_BIT), .FAULT_VAL(FAULT_VAL)) net1_i (
        .x(q_a), .fault_en(inject_fault), .y(net1_y)
    );

    example_net #(.W(W), .KIND(1), .FAULT_BIT(0), .FAULT_VAL(1'b0)) net2_i (
        .x(q_b), .fault_en(1'b0), .y(net2_y)
    );

    selftest_seq #(
        .W(W), .RUN1_LEN(RUN1_LEN), .RUN2_LEN(RUN2_LEN),
        .SEED1(SEED1), .SEED2(SEED2), .EXP1(EXP1), .EXP2(EXP2)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .so_a(so_a), .so_b(so_b),
        .mode_a(mode_a), .mode_b(mode_b), .si_a(si_a), .si_b(si_b),
        .done(done), .pass1(pass1), .pass2(pass2)
    );

    assert_roles_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == RM_GEN) |-> (mode_b == RM_COMPACT));
endmodule

// File: tb/ring_selftest_tb_top.sv
`timescale 1ns/1ps
module ring_selftest_tb_top;
    // Arithmetic model, W = 4, recurrence taps on bits 3 and 2.
    function automatic int gen_step(int q);
        return ((q << 1) & 15) | (((q >> 3) ^ (q >> 2)) & 1);
    endfunction

    function automatic int net1(int x, int flt, int fv);
        int y = 0;
        for (int b = 0; b < 4; b++)
            y |= ((((x >> b) & 1) ^ (((x >> ((b + 1) % 4)) & 1) & ((x >> ((b + 2) % 4)) & 1))) << b);
        if (flt != 0) y = (y & 14) | fv;
        return y;
    endfunction

    function automatic int net2(int x);
        int y = 0;
        for (int b = 0; b < 4; b++)
            y |= ((1 ^ ((x >> b) & 1) ^ ((x >> ((b + 3) % 4)) & 1)) << b);
        return y;
    endfunction

    function automatic int sig1(int seed, int n, int flt, int fv);
        int ra = seed, rb = 0, nb;
        for (int k = 0; k < n; k++) begin
            nb = gen_step(rb) ^ net1(ra, flt, fv);
            ra = gen_step(ra);
            rb = nb;
        end
        return rb;
    endfunction

    function automatic int sig2(int seed, int n);
        int ra = 0, rb = seed, na;
        for (int k = 0; k < n; k++) begin
            na = gen_step(ra) ^ net2(rb);
            rb = gen_step(rb);
            ra = na;
        end
        return ra;
    endfunction

    localparam int I_S1 = 8, I_S2 = 6, I_N1 = 6, I_N2 = 5;
    localparam int B_S1 = 7, B_S2 = 15, B_N1 = 1, B_N2 = 2;
    localparam int I_EXP1 = sig1(I_S1, I_N1, 0, 0);
    localparam int I_EXP2 = sig2(I_S2, I_N2);
    localparam int B_EXP1 = sig1(B_S1, B_N1, 0, 0) ^ 4;
    localparam int B_EXP2 = sig2(B_S2, B_N2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic inject_fault = 1'b0;
    logic done_i, pass1_i, pass2_i, done_b, pass1_b, pass2_b;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ring_selftest #(
        .RUN1_LEN(I_N1), .RUN2_LEN(I_N2), .SEED1(4'(I_S1)), .SEED2(4'(I_S2)),
        .EXP1(4'(I_EXP1)), .EXP2(4'(I_EXP2)), .FAULT_BIT(0), .FAULT_VAL(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .inject_fault(inject_fault),
        .done(done_i), .pass1(pass1_i), .pass2(pass2_i)
    );

    ring_selftest #(
        .RUN1_LEN(B_N1), .RUN2_LEN(B_N2), .SEED1(4'(B_S1)), .SEED2(4'(B_S2)),
        .EXP1(4'(B_EXP1)), .EXP2(4'(B_EXP2)), .FAULT_BIT(0), .FAULT_VAL(1'b0)
    ) dut_b (
        .clk(clk), .rst_n(rst_n), .start(start), .inject_fault(inject_fault),
        .done(done_b), .pass1(pass1_b), .pass2(pass2_b)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One complete self-test run on both instances.
    task automatic run_test(input int flt, input int stray_start);
        int lat_i = -1, lat_b = -1;
        int hold_i, hold_b;
        @(negedge clk);
        inject_fault = flt[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 done cleared after start (main)", done_i, 0);
        check("R11 pass cleared after start (main)", {pass1_i, pass2_i}, 0);
        check("R11 done cleared after start (short)", done_b, 0);
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            start = (stray_start != 0 && (c == 5 || c == 12)) ? 1'b1 : 1'b0;
            if (done_i && lat_i < 0) lat_i = c;
            if (done_b && lat_b < 0) lat_b = c;
        end
        start = 1'b0;
        check("R2 R10 completion latency (main)", lat_i, 3 * 4 + I_N1 + I_N2);
        check("R2 R10 completion latency (short)", lat_b, 3 * 4 + B_N1 + B_N2);
        check("R3 R4 R5 R7 R8 pass1 (main)", pass1_i,
              (sig1(I_S1, I_N1, flt, 1) == I_EXP1) ? 1 : 0);
        check("R3 R6 R7 R8 pass2 (main)", pass2_i, 1);
        check("R3 R4 R5 R7 R8 pass1 (short)", pass1_b,
              (sig1(B_S1, B_N1, flt, 0) == B_EXP1) ? 1 : 0);
        check("R3 R6 R7 R8 pass2 (short)", pass2_b, 1);
        hold_i = {done_i, pass1_i, pass2_i};
        hold_b = {done_b, pass1_b, pass2_b};
        repeat (9) @(negedge clk);
        check("R9 results held (main)", {done_i, pass1_i, pass2_i}, hold_i);
        check("R9 results held (short)", {done_b, pass1_b, pass2_b}, hold_b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset done (main)", done_i, 0);
        check("R1 reset pass (main)", {pass1_i, pass2_i}, 0);
        check("R1 reset done/pass (short)", {done_b, pass1_b, pass2_b}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle without start", {done_i, done_b}, 0);
        // The fault must actually disturb the main phase-one signature.
        check("R8 model sanity: fault changes signature",
              (sig1(I_S1, I_N1, 1, 1) != I_EXP1) ? 1 : 0, 1);
        run_test(0, 0);
        run_test(1, 1);
        run_test(0, 1);
        run_test(1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule